// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a synchronous pipelined burst SRAM that accepts a read or a write on every enabled clock edge. It needs no idle cycle when the traffic turns from reads to writes or back. Commands and addresses are captured on the rising edge. Read data comes out of an output register two enabled cycles after the read command. Write data is taken two enabled cycles after its write command, so a read and a write can share one pipeline slot pattern with no bubbles. Separate input and output data ports replace a shared bus. A flag marks the cycles in which the output would drive.

A write whose data has not yet arrived stays in a short address pipeline. A read that targets that address one cycle later gets the arriving write data for the written lanes, merged with the stored contents for the other lanes. Bursts of up to four beats, and longer if they wrap, step the two low address bits in linear or interleaved order. A clock-enable input freezes the whole block.

Top module: `zt_sram`

## Requirements
- R1: A read command accepted at an enabled edge puts the addressed word on `rdata` after the second following enabled edge. `rdata_oe` is 1 in exactly that cycle. When no read completes, `rdata` keeps its previous value.
- R2: While `clk_en` is 0, no command is taken, no write is committed and `rdata`/`rdata_oe` hold their values. All latencies count enabled edges only.
- R3: Byte-lane select `lane_wr_n[i]` is active low and covers bits `[9*i+8 : 9*i]`. A lane whose select is 1 keeps its stored value.
- R4: A load cycle (`adv_ld`=0) selects the block only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. Otherwise the cycle is a deselect: nothing is read or written, and `rdata_oe` is 0 in its data cycle.
- R5: The data for a write command is sampled on `wdata` at the second enabled edge after the command.
- R6: `rdata_oe` is 0 in the data cycle of a write.
- R7: A read issued one enabled cycle after a write to the same address returns the write's data in the lanes it wrote, and the stored data in the other lanes.
- R8: With `adv_ld`=1 the burst continues. It keeps the read/write type of its load cycle and the upper address bits. For beat n after the load, the low two bits are start+n mod 4 when the load had `burst_ileave`=0, or start XOR n when it had `burst_ileave`=1. Lane selects and write data are taken per beat.
- R9: Advancing past the fourth beat keeps wrapping inside the same 4-word block, with n taken mod 4.
- R10: An advance with no active burst (after a deselect or reset) is a deselect.
- R11: A deselect does not cancel writes issued before it. Their data is still taken and committed.
- R12: A synchronous active-low reset clears the command pipelines, `rdata_oe` and `rdata`. A write pending at reset is dropped, and the array keeps unknown contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Clock enable; 0 freezes all state |
| addr | input | ADDR_W | Word address for load cycles |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 0 = write, 1 = read (load cycles) |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| adv_ld | input | 1 | 1 = advance burst, 0 = load new command |
| burst_ileave | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| wdata | input | LANES*LANE_W | Write data, two enabled cycles after command |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_oe | output | 1 | High in the cycle read data is valid |

## Verification
The bench targets a read one cycle after a write to the same address with only some lanes written. A design without forwarding would return the stale word there. It also targets stalls placed between a write command and its data; a design that counts raw cycles would take the wrong `wdata`. Deselects with a single wrong select level, and advances with no burst active, are exercised; a wrong decode would read or write. Long bursts run in both orders. A design that carried into the upper bits or used the wrong step would read outside the 4-word block. A reset applied while writes are in flight checks that the output flag and data clear.

// File: rtl/zt_sram_pkg.sv
// Shared types and helpers for the zero-turnaround SRAM.
// Assumes burst sequencing only touches the two low address bits.
package zt_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits for beat n of a burst starting at 'start'.
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] n,
                                            input logic       ileave);
        return ileave ? (start ^ n) : (start + n);
    endfunction

endpackage

// File: rtl/zt_cmd_ctrl.sv
// Command decode and burst sequencer: registers one command per enabled
// edge into stage 1. Load cycles check the three selects; advance cycles
// step the burst. Assumes ADDR_W > 2.
module zt_cmd_ctrl
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              adv_ld,
    input  logic              burst_ileave,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_be
);

    logic              selected;
    logic              burst_act;
    logic              burst_wr;
    logic              burst_il;
    logic [ADDR_W-1:0] base_addr;
    logic [1:0]        beat_cnt;
    logic [1:0]        nxt_cnt;
    op_e               nxt_op;
    logic [ADDR_W-1:0] nxt_addr;

    assign selected = !sel1_n && sel2 && !sel3_n;
    assign nxt_cnt  = beat_cnt + 2'd1;

    // Decode the command presented this cycle.
    always_comb begin
        nxt_op   = OP_IDLE;
        nxt_addr = s1_addr;
        if (!adv_ld) begin
            if (selected) begin
                nxt_op   = wr_n ? OP_READ : OP_WRITE;
                nxt_addr = addr;
            end
        end else if (burst_act) begin
            nxt_op   = burst_wr ? OP_WRITE : OP_READ;
            nxt_addr = {base_addr[ADDR_W-1:2],
                        beat_low(base_addr[1:0], nxt_cnt, burst_il)};
        end
    end

    // Register stage 1 and the burst state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op     <= OP_IDLE;
            s1_addr   <= '0;
            s1_be     <= '0;
            burst_act <= 1'b0;
            burst_wr  <= 1'b0;
            burst_il  <= 1'b0;
            base_addr <= '0;
            beat_cnt  <= 2'd0;
        end else if (clk_en) begin
            s1_op   <= nxt_op;
            s1_addr <= nxt_addr;
            s1_be   <= ~lane_wr_n;
            if (!adv_ld) begin
                burst_act <= selected;
                burst_wr  <= !wr_n;
                burst_il  <= burst_ileave;
                base_addr <= addr;
                beat_cnt  <= 2'd0;
            end else if (burst_act) begin
                beat_cnt <= nxt_cnt;
            end
        end
    end

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && !adv_ld && !selected |=> s1_op == OP_IDLE); // R4
    AST_ADV_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && adv_ld && !burst_act |=> s1_op == OP_IDLE); // R10
    AST_BURST_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && adv_ld && burst_act
        |=> s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])); // R9
    AST_CMD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(s1_op) && $stable(s1_addr)); // R2

endmodule

// File: rtl/zt_mem_array.sv
// Byte-lane memory: one bank per lane, synchronous write with per-lane
// enable, combinational read. Contents are never reset.
module zt_mem_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES-1:0]          wr_be,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        // Commit this lane when its select is active.
        always_ff @(posedge clk) begin
            if (wr_en && wr_be[g])
                bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
    end

endmodule

// File: rtl/zt_fwd_merge.sv
// Coherency merge: per lane, picks arriving write data over array data
// when a pending write hits the read address and wrote that lane.
module zt_fwd_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    hit,
    input  logic [LANES-1:0]        wr_be,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [LANES*LANE_W-1:0] arr_data,
    output logic [LANES*LANE_W-1:0] out_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign out_data[g*LANE_W +: LANE_W] = (hit && wr_be[g])
            ? wr_data[g*LANE_W +: LANE_W]
            : arr_data[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/zt_sram.sv
// Top of the zero-turnaround SRAM. Stage 1 holds the decoded command,
// stage 2 holds the array read and the write waiting for its data, and
// the output register presents read data. Write data is consumed when the
// write reaches stage 2. Assumes every lane is written before it is read.
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    adv_ld,
    input  logic                    burst_ileave,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);

    localparam int DATA_W = LANES * LANE_W;

    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_be;
    op_e               s2_op;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_be;
    logic [DATA_W-1:0] s2_rd;
    logic [DATA_W-1:0] arr_q;
    logic [DATA_W-1:0] merged;
    logic              fwd_hit;
    logic              commit;

    zt_cmd_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .adv_ld(adv_ld), .burst_ileave(burst_ileave),
        .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be)
    );

    assign commit  = clk_en && rst_n && (s2_op == OP_WRITE);
    assign fwd_hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);

    zt_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .wr_en(commit), .wr_addr(s2_addr), .wr_be(s2_be),
        .wr_data(wdata), .rd_addr(s1_addr), .rd_data(arr_q)
    );

    zt_fwd_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_fwd (
        .hit(fwd_hit), .wr_be(s2_be), .wr_data(wdata),
        .arr_data(arr_q), .out_data(merged)
    );

    // Advance stage 2 and capture the coherent array read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_op   <= OP_IDLE;
            s2_addr <= '0;
            s2_be   <= '0;
            s2_rd   <= '0;
        end else if (clk_en) begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
            s2_rd   <= merged;
        end
    end

    // Output register: load read data and mark it valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end else if (clk_en) begin
            rdata_oe <= (s2_op == OP_READ);
            if (s2_op == OP_READ)
                rdata <= s2_rd;
        end
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && s2_op == OP_READ |=> rdata_oe); // R1
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && s2_op == OP_WRITE |=> !rdata_oe); // R6
    AST_OUT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(rdata) && $stable(rdata_oe)); // R2
    AST_FWD_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && s1_op == OP_READ && fwd_hit && (&s2_be)
        |=> s2_rd == $past(wdata)); // R7

endmodule

// File: tb/zt_sram_test.sv
// Bench for zt_sram: directed corner cases then seeded random traffic,
// checked against a command-order reference model.
module zt_sram_test;

    localparam int AW    = 6;
    localparam int L     = 4;
    localparam int LW    = 9;
    localparam int DW    = L * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          sel1_n = 1'b1;
    logic          sel2 = 1'b0;
    logic          sel3_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [L-1:0]  lane_wr_n = '1;
    logic          adv_ld = 1'b0;
    logic          burst_ileave = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    always #5 clk = ~clk;

    zt_sram #(.ADDR_W(AW), .LANES(L), .LANE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .adv_ld(adv_ld), .burst_ileave(burst_ileave),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state: array, two in-flight commands, burst tracker.
    logic [DW-1:0] mdl [DEPTH];
    int            p1_op = 0, p2_op = 0, p1_addr = 0, p2_addr = 0;
    logic [L-1:0]  p1_be = '0, p2_be = '0;
    logic [DW-1:0] p1_d = '0, p2_d = '0;
    string         p1_tag = "R12", p2_tag = "R12";
    bit            m_act = 0, m_wr = 0, m_il = 0;
    int            m_base = 0, m_cnt = 0;

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [L-1:0] be);
        logic [DW-1:0] r = old_w;
        for (int i = 0; i < L; i++)
            if (be[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
        return r;
    endfunction

    function automatic int beat_addr(input int base, input int n, input bit il);
        int lo = base % 4;
        int nl = il ? (lo ^ n) : ((lo + n) % 4);
        return base - lo + nl;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, sample 1 ns after the rising edge.
    task automatic cyc(input bit en, input bit ld, input bit s1n, input bit s2v,
                       input bit s3n, input bit wrn, input int a,
                       input logic [L-1:0] ben, input bit il,
                       input logic [DW-1:0] d, input string tag);
        logic [DW-1:0] prev_rd;
        logic          prev_oe;
        logic [63:0]   junk;
        int            op = 0, ea = 0;
        string         t = tag;
        @(negedge clk);
        junk = {$urandom(), $urandom()};
        clk_en = en; adv_ld = ld; sel1_n = s1n; sel2 = s2v; sel3_n = s3n;
        wr_n = wrn; addr = a[AW-1:0]; lane_wr_n = ben; burst_ileave = il;
        wdata = (p2_op == 2) ? p2_d : junk[DW-1:0];
        prev_rd = rdata; prev_oe = rdata_oe;
        if (!ld) begin
            if (!s1n && s2v && !s3n) begin op = wrn ? 1 : 2; ea = a; end
        end else if (m_act) begin
            op = m_wr ? 2 : 1;
            ea = beat_addr(m_base, (m_cnt + 1) % 4, m_il);
        end
        if (op == 1 && p1_op == 2 && p1_addr == ea) t = "R7";
        if (op == 2 && t == "R1") t = "R6";
        @(posedge clk); #1;
        if (en) begin
            if (p2_op == 2) mdl[p2_addr] = lane_merge(mdl[p2_addr], p2_d, p2_be);
            check(rdata_oe == (p2_op == 1), p2_tag, "oe",
                  DW'(rdata_oe), DW'(p2_op == 1));
            if (p2_op == 1)
                check(rdata === mdl[p2_addr], p2_tag, "rdata", rdata, mdl[p2_addr]);
            if (!ld) begin
                m_act = !s1n && s2v && !s3n; m_base = a; m_cnt = 0;
                m_wr = !wrn; m_il = il;
            end else if (m_act) m_cnt = (m_cnt + 1) % 4;
            p2_op = p1_op; p2_addr = p1_addr; p2_be = p1_be; p2_d = p1_d; p2_tag = p1_tag;
            p1_op = op; p1_addr = ea; p1_be = ~ben; p1_d = d; p1_tag = t;
        end else begin
            check(rdata === prev_rd && rdata_oe === prev_oe, "R2", "stall hold",
                  rdata, prev_rd);
        end
    endtask

    task automatic idle(input string tag);
        cyc(1, 0, 1, 1, 0, 1, 0, '1, 0, '0, tag);
    endtask
    task automatic wr(input int a, input logic [L-1:0] ben,
                      input logic [DW-1:0] d, input string tag);
        cyc(1, 0, 0, 1, 0, 0, a, ben, 0, d, tag);
    endtask
    task automatic rd(input int a, input string tag);
        cyc(1, 0, 0, 1, 0, 1, a, '1, 0, '0, tag);
    endtask
    task automatic adv(input logic [L-1:0] ben, input logic [DW-1:0] d,
                       input string tag);
        cyc(1, 1, 1, 0, 1, 1, 0, ben, 0, d, tag);
    endtask
    task automatic stall();
        cyc(0, 0, 0, 1, 0, 1, 7, '1, 0, '0, "R2");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; clk_en = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(rdata_oe == 1'b0, "R12", "oe after reset", DW'(rdata_oe), '0);
        check(rdata == '0, "R12", "rdata after reset", rdata, '0);
        @(negedge clk);
        rst_n = 1'b1;
        p1_op = 0; p2_op = 0; p1_tag = "R12"; p2_tag = "R12"; m_act = 0;
    endtask

    function automatic logic [DW-1:0] rnd_word();
        logic [63:0] v = {$urandom(), $urandom()};
        return v[DW-1:0];
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        for (int a = 0; a < DEPTH; a++) wr(a, '0, rnd_word(), "R1");
        idle("R4"); idle("R4");

        // R3: partial lane write, read back later.
        wr(5, 4'b1010, 36'hA_BCDE_F012, "R3");
        idle("R3"); idle("R3"); rd(5, "R3"); idle("R3"); idle("R3");
        // R7: read one cycle after partial write to the same address.
        wr(9, 4'b0110, 36'h1_2345_6789, "R7"); rd(9, "R7");
        wr(10, 4'b0000, 36'h9_8765_4321, "R7"); rd(10, "R7");
        idle("R7"); idle("R7");
        // R5: write then a read two cycles later.
        wr(11, '0, 36'h5_5555_AAAA, "R5"); idle("R5"); rd(11, "R5");
        idle("R5"); idle("R5");
        // R2: stalls between a write command and its data.
        wr(12, '0, 36'h3_C3C3_C3C3, "R2"); stall(); stall(); idle("R2");
        stall(); rd(12, "R2"); stall(); idle("R2"); stall(); idle("R2");
        // R4: a write with one select inactive must not touch the array.
        cyc(1, 0, 0, 0, 0, 0, 20, '0, 0, 36'hF_FFFF_FFFF, "R4");
        cyc(1, 0, 0, 1, 1, 0, 20, '0, 0, 36'hF_FFFF_FFFF, "R4");
        idle("R4"); rd(20, "R4"); idle("R4"); idle("R4");
        // R10: advance with no active burst.
        idle("R10"); adv('1, '0, "R10"); adv('1, '0, "R10");
        idle("R10"); idle("R10");
        // R11: deselects behind a pending write.
        wr(30, '0, 36'h7_0F0F_0F0F, "R11"); idle("R11"); idle("R11");
        rd(30, "R11"); idle("R11"); idle("R11");
        // R8/R9: linear and interleaved read bursts past four beats.
        rd(45, "R8");
        for (int i = 0; i < 3; i++) adv('1, '0, "R8");
        for (int i = 0; i < 3; i++) adv('1, '0, "R9");
        cyc(1, 0, 0, 1, 0, 1, 46, '1, 1, '0, "R8");
        for (int i = 0; i < 3; i++) adv('1, '0, "R8");
        for (int i = 0; i < 3; i++) adv('1, '0, "R9");
        // Interleaved write burst, then read it back.
        cyc(1, 0, 0, 1, 0, 0, 51, '0, 1, rnd_word(), "R8");
        for (int i = 0; i < 5; i++) adv(4'b0100, rnd_word(), "R9");
        cyc(1, 0, 0, 1, 0, 1, 48, '1, 0, '0, "R8");
        for (int i = 0; i < 3; i++) adv('1, '0, "R8");
        idle("R8"); idle("R8");

        // Constrained random traffic.
        for (int n = 0; n < 3000; n++) begin
            bit en  = ($urandom % 6) != 0;
            bit ld  = m_act ? ($urandom % 2) : (($urandom % 8) == 0);
            logic [L-1:0] ben = (($urandom % 4) == 0) ? '0 : L'($urandom);
            cyc(en, ld, ($urandom % 6) == 0, ($urandom % 6) != 0,
                ($urandom % 6) == 0, $urandom % 2, $urandom % DEPTH, ben,
                $urandom % 2, rnd_word(), ld ? "R8" : "R1");
        end

        // R12: reset with writes in flight.
        wr(3, '0, rnd_word(), "R12"); wr(4, '0, rnd_word(), "R12");
        do_reset();
        idle("R12"); idle("R12");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule